// File: doc/BRIEF.md
# Framed Packet Header Validator

This block watches a one-beat-per-clock data stream qualified by a valid strobe. Every unbroken run of valid beats is one packet. The first four beats of a packet are its header. The block stores the header fields, counts the beats, and works out from the packet type how many payload beats should follow.

When valid drops, the block checks the stored header and the beat count. One cycle later it raises exactly one of two one-cycle pulses. One pulse means the packet is good. The other means the packet is in error and comes with a reason code.

The block only judges packets. It does not store or forward payload, and it never acts on a bad packet beyond flagging it. It is meant to sit beside a datapath as an in-line protocol monitor.

Top module: `hdr_validator`

## Requirements
- R1: A packet ends at the first rising clock edge that samples `in_valid` low after an edge that sampled it high. In the next cycle exactly one of `pkt_good` or `pkt_err` is high, for that one cycle only. Neither output pulses while a packet is in progress.
- R2: The beat count rises by one on each edge that samples `in_valid` high and returns to zero on each edge that samples it low. It saturates at its maximum instead of wrapping, so a packet far longer than legal still reports overrun (code 5).
- R3: Header beats arrive in this fixed order: beat 0 is type, beat 1 is length, beat 2 is the upper address byte and beat 3 is the lower address byte. The address is {beat 2, beat 3}.
- R4: The legal type values are READ=0, WRITE=1, RESP=2 and ERR=3. Any other value gives error code 1.
- R5: The length field must lie in the range 1 to 128 inclusive. Zero, or any value above 128, gives error code 2.
- R6: The expected number of payload beats equals the length field for WRITE and RESP. For READ and ERR it is zero.
- R7: The address must lie within ADDR_LO to ADDR_HI inclusive (defaults 0x0100 and 0x7FFF). An address outside that range gives error code 3.
- R8: Fewer payload beats than expected gives error code 4. A packet shorter than the 4 header beats also gives code 4, whatever its field values.
- R9: More payload beats than expected gives error code 5.
- R10: When several errors apply, the lowest code wins, in the order type, length, address, truncation, overrun. Code 4 for a packet shorter than 4 beats overrides all of them.
- R11: While reset is asserted, `pkt_good`, `pkt_err` and `err_code` are all zero.
- R12: `err_code` is 0 whenever `pkt_err` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat qualifier; a low level ends the current packet |
| in_data | input | BEAT_W | Beat data |
| pkt_good | output | 1 | One-cycle pulse: the packet passed every check |
| pkt_err | output | 1 | One-cycle pulse: the packet failed a check |
| err_code | output | 3 | Error reason, valid while `pkt_err` is high (1 type, 2 length, 3 address, 4 truncated, 5 overrun) |

## Verification
The assertions check the cycle-level contract on every cycle:
- the two result pulses never overlap and each lasts one cycle;
- a result appears only in the cycle after valid was sampled low;
- the code is zero on a good result and within 1 to 5 on an error;
- the beat counter steps, clears and saturates correctly;
- each header field is stored from the matching beat.

Whether the right verdict and code come out for a given header and length can only be shown by the bench's directed packets. These include:
- the address range edges;
- length 0, 128 and 129;
- type-dependent payload sizes;
- packets shorter than the header;
- a packet long enough to saturate the counter;
- packets with several faults at once, to test priority.

// File: rtl/hdrv_pkg.sv
package hdrv_pkg;
  typedef enum logic [2:0] {
    RC_NONE  = 3'd0,
    RC_TYPE  = 3'd1,
    RC_LEN   = 3'd2,
    RC_ADDR  = 3'd3,
    RC_SHORT = 3'd4,
    RC_LONG  = 3'd5
  } reason_e;

  localparam int HDR_BEATS = 4;
  localparam int HB_TYPE   = 0;
  localparam int HB_LEN    = 1;
  localparam int HB_ADDR_H = 2;
  localparam int HB_ADDR_L = 3;
endpackage

// File: rtl/hdrv_beat_count.sv
module hdrv_beat_count #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt;
    if (!in_valid)           cnt_d = '0;
    else if (cnt != CNT_MAX) cnt_d = cnt + 1'b1;
    else                     cnt_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  // R2: counter clears, steps and saturates
  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> cnt == '0);
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);
  a_r2_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cnt == CNT_MAX) |=> cnt == CNT_MAX);
endmodule

// File: rtl/hdrv_hdr_capture.sv
module hdrv_hdr_capture
  import hdrv_pkg::*;
#(
  parameter int BEAT_W = 8,
  parameter int CNT_W  = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [BEAT_W-1:0]           in_data,
  input  logic [CNT_W-1:0]            cnt,
  output logic [HDR_BEATS-1:0][BEAT_W-1:0] hdr
);
  for (genvar g = 0; g < HDR_BEATS; g++) begin : g_field
    logic              ld;
    logic [BEAT_W-1:0] fld_d;

    always_comb begin
      ld    = in_valid && (cnt == CNT_W'(g));
      fld_d = in_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  hdr[g] <= '0;
      else if (ld) hdr[g] <= fld_d;
    end

    // R3: each header field is taken from its own beat
    a_r3_field_load: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cnt == CNT_W'(g)) |=> hdr[g] == $past(in_data));
  end
endmodule

// File: rtl/hdrv_judge.sv
module hdrv_judge
  import hdrv_pkg::*;
#(
  parameter int              BEAT_W  = 8,
  parameter int              CNT_W   = 9,
  parameter int              MIN_LEN = 1,
  parameter int              MAX_LEN = 128,
  parameter logic [BEAT_W-1:0] T_READ  = 0,
  parameter logic [BEAT_W-1:0] T_WRITE = 1,
  parameter logic [BEAT_W-1:0] T_RESP  = 2,
  parameter logic [BEAT_W-1:0] T_ERR   = 3,
  parameter logic [2*BEAT_W-1:0] ADDR_LO = 16'h0100,
  parameter logic [2*BEAT_W-1:0] ADDR_HI = 16'h7FFF
) (
  input  logic [HDR_BEATS-1:0][BEAT_W-1:0] hdr,
  input  logic [CNT_W-1:0]                 cnt,
  output reason_e                          reason
);
  logic [BEAT_W-1:0]   typ, len;
  logic [2*BEAT_W-1:0] addr;
  logic                type_ok, len_ok, addr_ok, has_pay, short_hdr;
  logic [CNT_W-1:0]    exp_pay, got_pay;

  always_comb begin
    typ       = hdr[HB_TYPE];
    len       = hdr[HB_LEN];
    addr      = {hdr[HB_ADDR_H], hdr[HB_ADDR_L]};
    type_ok   = (typ == T_READ) || (typ == T_WRITE) || (typ == T_RESP) || (typ == T_ERR);
    len_ok    = (len >= BEAT_W'(MIN_LEN)) && (len <= BEAT_W'(MAX_LEN));
    addr_ok   = (addr >= ADDR_LO) && (addr <= ADDR_HI);
    has_pay   = (typ == T_WRITE) || (typ == T_RESP);
    exp_pay   = has_pay ? CNT_W'(len) : '0;
    short_hdr = cnt < CNT_W'(HDR_BEATS);
    got_pay   = cnt - CNT_W'(HDR_BEATS);

    if (short_hdr)            reason = RC_SHORT;
    else if (!type_ok)        reason = RC_TYPE;
    else if (!len_ok)         reason = RC_LEN;
    else if (!addr_ok)        reason = RC_ADDR;
    else if (got_pay < exp_pay) reason = RC_SHORT;
    else if (got_pay > exp_pay) reason = RC_LONG;
    else                      reason = RC_NONE;
  end
endmodule

// File: rtl/hdr_validator.sv
module hdr_validator
  import hdrv_pkg::*;
#(
  parameter int              BEAT_W  = 8,
  parameter int              CNT_W   = 9,
  parameter int              MIN_LEN = 1,
  parameter int              MAX_LEN = 128,
  parameter logic [BEAT_W-1:0] T_READ  = 0,
  parameter logic [BEAT_W-1:0] T_WRITE = 1,
  parameter logic [BEAT_W-1:0] T_RESP  = 2,
  parameter logic [BEAT_W-1:0] T_ERR   = 3,
  parameter logic [2*BEAT_W-1:0] ADDR_LO = 16'h0100,
  parameter logic [2*BEAT_W-1:0] ADDR_HI = 16'h7FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BEAT_W-1:0] in_data,
  output logic              pkt_good,
  output logic              pkt_err,
  output logic [2:0]        err_code
);
  logic [CNT_W-1:0]                 cnt;
  logic [HDR_BEATS-1:0][BEAT_W-1:0] hdr;
  reason_e                          reason;
  logic                             vld_q, boundary;
  logic                             good_d, err_d;
  logic [2:0]                       code_d;

  hdrv_beat_count #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cnt(cnt));

  hdrv_hdr_capture #(.BEAT_W(BEAT_W), .CNT_W(CNT_W)) i_cap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cnt(cnt), .hdr(hdr));

  hdrv_judge #(
    .BEAT_W(BEAT_W), .CNT_W(CNT_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN),
    .T_READ(T_READ), .T_WRITE(T_WRITE), .T_RESP(T_RESP), .T_ERR(T_ERR),
    .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)
  ) i_judge (.hdr(hdr), .cnt(cnt), .reason(reason));

  always_comb begin
    boundary = vld_q && !in_valid;
    good_d   = boundary && (reason == RC_NONE);
    err_d    = boundary && (reason != RC_NONE);
    code_d   = err_d ? reason : RC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      pkt_good <= 1'b0;
      pkt_err  <= 1'b0;
      err_code <= '0;
    end else begin
      vld_q    <= in_valid;
      pkt_good <= good_d;
      pkt_err  <= err_d;
      err_code <= code_d;
    end
  end

  // R1: results are exclusive, one cycle wide, and follow a sampled-low valid
  a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_good && pkt_err));
  a_r1_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_good || pkt_err) |-> !$past(in_valid));
  a_r1_single: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_good || pkt_err) |=> !(pkt_good || pkt_err));
  // R12: no code without an error pulse
  a_r12_quiet_code: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_err |-> err_code == 3'd0);
  // R10: reported codes stay within the defined set
  a_r10_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_err |-> (err_code >= 3'd1 && err_code <= 3'd5));
endmodule

// File: tb/test_hdr_validator.sv
module test_hdr_validator;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       pkt_good, pkt_err;
  logic [2:0] err_code;
  int total = 0;
  int bad = 0;
  bit done = 0;

  hdr_validator i_hdr_validator (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .pkt_good(pkt_good), .pkt_err(pkt_err), .err_code(err_code));

  always #4ns clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int t, input int l, input int a, input int n);
    int pay, want;
    if (n < 4) return 4;
    if (t > 3) return 1;
    if (l < 1 || l > 128) return 2;
    if (a < 'h0100 || a > 'h7FFF) return 3;
    pay  = n - 4;
    want = (t == 1 || t == 2) ? l : 0;
    if (pay < want) return 4;
    if (pay > want) return 5;
    return 0;
  endfunction

  // Drives n beats of [t, l, ah, al, payload...]; one idle cycle follows.
  task automatic send(input string req, input int t, input int l, input int ah,
                      input int al, input int n);
    int e, act, early;
    e = exp_code(t, l, ah * 256 + al, n);
    early = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      case (i)
        0: in_data = 8'(t);
        1: in_data = 8'(l);
        2: in_data = 8'(ah);
        3: in_data = 8'(al);
        default: in_data = 8'(i);
      endcase
      if (pkt_good || pkt_err) early++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (pkt_good || pkt_err) early++;
    chk(early == 0, "R1 no pulse mid-packet", early, 0);
    @(negedge clk);
    act = (e == 0) ? (pkt_good && !pkt_err && err_code == 0 ? 0 : 8 + err_code)
                   : (pkt_err && !pkt_good ? int'(err_code) : 9);
    chk(act == e, req, act, e);
    @(negedge clk);
    chk(!pkt_good && !pkt_err && err_code == 0, "R1/R12 pulse one cycle",
        {pkt_good, pkt_err, err_code}, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!pkt_good && !pkt_err && err_code == 0, "R11 reset outputs",
        {pkt_good, pkt_err, err_code}, 0);
    in_valid = 1'b1;
    in_data  = 8'h05;
    repeat (3) @(negedge clk);
    chk(!pkt_good && !pkt_err, "R11 held in reset", {pkt_good, pkt_err}, 0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!pkt_good && !pkt_err && err_code == 0, "R11 after release",
        {pkt_good, pkt_err, err_code}, 0);
  endtask

  task automatic t_good();
    send("R6 READ no payload good",   0, 10,  8'h12, 8'h34, 4);
    send("R6 WRITE 3 payload good",   1, 3,   8'h01, 8'h00, 7);
    send("R5 RESP len 128 good",      2, 128, 8'h7F, 8'hFF, 132);
    send("R3 ERR len 1 good",         3, 1,   8'h20, 8'h00, 4);
  endtask

  task automatic t_type();
    send("R4 type 4 rejected",   4,   5, 8'h10, 8'h00, 4);
    send("R4 type 255 rejected", 255, 5, 8'h10, 8'h00, 4);
  endtask

  task automatic t_len();
    send("R5 len 0 rejected",   0, 0,   8'h10, 8'h00, 4);
    send("R5 len 129 rejected", 1, 129, 8'h10, 8'h00, 133);
  endtask

  task automatic t_addr();
    send("R7 addr 0x00FF below", 0, 1, 8'h00, 8'hFF, 4);
    send("R7 addr 0x8000 above", 0, 1, 8'h80, 8'h00, 4);
    send("R7 addr 0x0100 edge",  0, 1, 8'h01, 8'h00, 4);
  endtask

  task automatic t_trunc();
    send("R8 two beats truncated",   1, 2, 8'h10, 8'h00, 2);
    send("R8 one beat bad type",     9, 0, 8'h00, 8'h00, 1);
    send("R8 WRITE short payload",   1, 5, 8'h10, 8'h00, 8);
  endtask

  task automatic t_over();
    send("R9 READ with payload",     0, 5, 8'h10, 8'h00, 5);
    send("R9 RESP one extra",        2, 2, 8'h10, 8'h00, 7);
    send("R2 saturated long packet", 1, 5, 8'h10, 8'h00, 600);
    send("R2 counter cleared after", 1, 2, 8'h10, 8'h00, 6);
  endtask

  task automatic t_prio();
    send("R10 type over length",    7, 0,   8'hFF, 8'hFF, 9);
    send("R10 length over address", 1, 200, 8'h00, 8'h00, 4);
    send("R10 address over trunc",  1, 9,   8'h90, 8'h00, 5);
  endtask

  initial begin
    t_reset();
    t_good();
    t_type();
    t_len();
    t_addr();
    t_trunc();
    t_over();
    t_prio();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8ns * 100000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule